// File: doc/BRIEF.md
# Section Address Translation Walker

This block turns a 32-bit virtual address into a physical address using a flat table of 4096 one-mebibyte section descriptors held in memory. A requester hands over a load or store, together with a flag that says whether the access is privileged, through a valid/ready pair. The block then issues a single read for the matching descriptor and waits for the data. It checks the descriptor type, the rights the domain register grants to the descriptor's domain and, for client domains, the permission field. It answers with a one-cycle response that carries either the translated address and the two cache attribute bits, or a 2-bit fault code.

Three configuration values come from the surrounding register file: the table base, a 32-bit domain rights word (two bits for each of the 16 domains) and an enable bit. When the enable bit is clear, no table read happens and the address passes through unchanged. Only one request is in flight at a time. Descriptor bit 4 and bits 19:12 and 9 are not examined. The cacheable and bufferable bits are forwarded and not acted on.

Top module: `sect_xlate`

## Requirements
- R1: With the enable bit set, an accepted request produces exactly one read strobe, in the cycle after acceptance, at address {table base bits 31:14, virtual bits 31:20, 2'b00}; table base bits 13:0 are ignored.
- R2: The request ready is high only when no request is in flight and no response is being presented, so one request at most is outstanding.
- R3: With the enable bit clear at acceptance, the response appears in the next cycle with physical address equal to the virtual address, fault 00, attributes 00, and no read strobe.
- R4: A granted translation reports physical address {descriptor bits 31:20, virtual bits 19:0}, attributes {descriptor bit 3 (cacheable), bit 2 (bufferable)}, fault 00, one cycle after the read data is marked valid.
- R5: A descriptor whose bits 1:0 are not 2'b10 gives fault code 01 (translation), ahead of any domain or permission result.
- R6: The domain number is descriptor bits 8:5; its rights field is domain-rights bits [2d+1:2d]. A field of 00 or 10 gives fault code 10 (domain).
- R7: A rights field of 11 (manager) grants the access whatever the permission field, privilege and direction.
- R8: A rights field of 01 (client) with permission field (descriptor bits 11:10) 00 gives fault code 11 (permission) for every access.
- R9: Client with permission field 01 grants privileged accesses and gives fault 11 for unprivileged ones.
- R10: Client with permission field 10 grants privileged accesses and unprivileged reads and faults unprivileged writes with code 11; permission field 11 grants all accesses.
- R11: Any faulting response carries physical address 0 and attributes 00.
- R12: Read data marked valid while no descriptor read is awaited is ignored and produces no response.
- R13: During and after reset, with no request, ready is high and the read strobe and response valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgTableBase | input | 32 | Translation table base; bits 31:14 used |
| cfgDomainAcc | input | 32 | Two rights bits per domain, domain d at [2d+1:2d] |
| cfgEnable | input | 1 | Translation enable; clear means pass-through |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqVaddr | input | 32 | Virtual address |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqPriv | input | 1 | 1 = privileged access |
| memRdValid | output | 1 | One-cycle descriptor read strobe |
| memRdAddr | output | 32 | Descriptor read address |
| memRspValid | input | 1 | Descriptor data valid |
| memRspData | input | 32 | Descriptor data |
| rspValid | output | 1 | One-cycle response strobe |
| rspPaddr | output | 32 | Physical address, 0 on fault |
| rspAttr | output | 2 | {cacheable, bufferable}, 00 on fault or bypass |
| rspFault | output | 2 | 00 none, 01 translation, 10 domain, 11 permission |

## Verification
A sequencer stuck outside its idle state shows at once as a ready that never returns after a response, and a missed return to idle shows as a second read strobe or a response that never comes, within a cycle or two of the data arriving. A stale captured address shows in the very response it belongs to, as a wrong read address or wrong low twenty bits of the physical address. Wrong decoding of the domain field or permission rules is caught by vectors that differ in one field only, where the fault code changes in the response cycle.

// File: rtl/sect_xlate_pkg.sv
package sect_xlate_pkg;
  localparam int ADDR_W   = 32;
  localparam int OFF_W    = 20;                  // bits inside one section
  localparam int IDX_W    = ADDR_W - OFF_W;      // table index bits
  localparam int ALIGN_W  = IDX_W + 2;           // table base alignment bits
  localparam int DOM_N    = 16;
  localparam int DOM_W    = $clog2(DOM_N);
  localparam int DACR_W   = 2 * DOM_N;

  // descriptor field positions
  localparam int AP_LSB   = 10;
  localparam int DOM_LSB  = 5;
  localparam int ATTR_LSB = 2;
  localparam logic [1:0] SECTION_TAG = 2'b10;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_XLATE  = 2'b01,
    FLT_DOMAIN = 2'b10,
    FLT_PERM   = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    DOM_NOACC  = 2'b00,
    DOM_CLIENT = 2'b01,
    DOM_RSVD   = 2'b10,
    DOM_MGR    = 2'b11
  } domRights_e;

  typedef struct packed {
    logic captureReq;   // latch request fields
    logic loadBypass;   // present untranslated response
    logic loadXlate;    // present checked response from descriptor
  } strobe_t;
endpackage

// File: rtl/sect_xlate_check.sv
module sect_xlate_check
  import sect_xlate_pkg::*;
(
  input  logic [ADDR_W-1:0] desc,
  input  logic [DACR_W-1:0] domainAcc,
  input  logic              isPriv,
  input  logic              isWrite,
  output fault_e            fault,
  output logic [IDX_W-1:0]  sectBase,
  output logic [1:0]        attr
);
  logic [1:0] domFields [DOM_N];
  logic [DOM_W-1:0] domIdx;
  logic [1:0] apField;
  domRights_e rights;
  logic permOk;
  logic unusedDescBits;

  genvar g;
  generate
    for (g = 0; g < DOM_N; g++) begin : g_dom
      assign domFields[g] = domainAcc[2*g +: 2];
    end
  endgenerate

  assign domIdx   = desc[DOM_LSB +: DOM_W];
  assign apField  = desc[AP_LSB +: 2];
  assign sectBase = desc[ADDR_W-1:OFF_W];
  assign attr     = desc[ATTR_LSB +: 2];
  assign rights   = domRights_e'(domFields[domIdx]);
  assign unusedDescBits = ^{desc[OFF_W-1:AP_LSB+2], desc[AP_LSB-1:DOM_LSB+DOM_W],
                            desc[DOM_LSB-1:ATTR_LSB+2]};

  always_comb begin
    unique case (apField)
      2'b00:   permOk = 1'b0;
      2'b01:   permOk = isPriv;
      2'b10:   permOk = isPriv || !isWrite;
      default: permOk = 1'b1;
    endcase
  end

  always_comb begin
    if (desc[1:0] != SECTION_TAG)   fault = FLT_XLATE;
    else if (rights == DOM_MGR)     fault = FLT_NONE;
    else if (rights == DOM_CLIENT)  fault = permOk ? FLT_NONE : FLT_PERM;
    else                            fault = FLT_DOMAIN;
  end
endmodule

// File: rtl/sect_xlate_ctrl.sv
module sect_xlate_ctrl
  import sect_xlate_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    cfgEnable,
  input  logic    memRspValid,
  output logic    reqReady,
  output logic    memRdValid,
  output logic    rspValid,
  output strobe_t strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_e;
  state_e state, stateNext;
  logic accept;

  assign reqReady   = (state == ST_IDLE) && !rspValid;
  assign accept     = reqValid && reqReady;
  assign memRdValid = (state == ST_ISSUE);

  assign strobe.captureReq = accept;
  assign strobe.loadBypass = accept && !cfgEnable;
  assign strobe.loadXlate  = (state == ST_WAIT) && memRspValid;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept && cfgEnable) stateNext = ST_ISSUE;
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT:  if (memRspValid) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rspValid <= 1'b0;
    end else begin
      state    <= stateNext;
      rspValid <= strobe.loadBypass || strobe.loadXlate;
    end
  end

  // R1: one strobe per request
  a_r1_single_fetch: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |=> !memRdValid);
  // R2: no acceptance while a fetch is out
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |-> !reqReady);
  // R2: response is a single-cycle pulse
  a_r2_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  // R3: bypass answers next cycle without a fetch
  a_r3_bypass_no_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !cfgEnable) |=> (rspValid && !memRdValid));
  // R12: stray data in idle gives nothing
  a_r12_stray_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !reqValid && memRspValid) |=> !rspValid);
endmodule

// File: rtl/sect_xlate_dp.sv
module sect_xlate_dp
  import sect_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic              reqPriv,
  input  logic [ADDR_W-1:0] cfgTableBase,
  input  logic [DACR_W-1:0] cfgDomainAcc,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic [1:0]        rspAttr,
  output fault_e            rspFault
);
  logic [ADDR_W-1:0] vaReg;
  logic wrReg, privReg;
  fault_e chkFault;
  logic [IDX_W-1:0] chkBase;
  logic [1:0] chkAttr;
  logic unusedBaseBits;

  assign unusedBaseBits = ^cfgTableBase[ALIGN_W-1:0];
  assign memRdAddr = {cfgTableBase[ADDR_W-1:ALIGN_W], vaReg[ADDR_W-1:OFF_W], 2'b00};

  sect_xlate_check u_check (
    .desc      (memRspData),
    .domainAcc (cfgDomainAcc),
    .isPriv    (privReg),
    .isWrite   (wrReg),
    .fault     (chkFault),
    .sectBase  (chkBase),
    .attr      (chkAttr)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg   <= '0;
      wrReg   <= 1'b0;
      privReg <= 1'b0;
    end else if (strobe.captureReq) begin
      vaReg   <= reqVaddr;
      wrReg   <= reqWrite;
      privReg <= reqPriv;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPaddr <= '0;
      rspAttr  <= '0;
      rspFault <= FLT_NONE;
    end else if (strobe.loadBypass) begin
      rspPaddr <= reqVaddr;
      rspAttr  <= '0;
      rspFault <= FLT_NONE;
    end else if (strobe.loadXlate) begin
      rspFault <= chkFault;
      if (chkFault == FLT_NONE) begin
        rspPaddr <= {chkBase, vaReg[OFF_W-1:0]};
        rspAttr  <= chkAttr;
      end else begin
        rspPaddr <= '0;
        rspAttr  <= '0;
      end
    end
  end

  // R4: section offset carried through unchanged
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.loadXlate) && rspFault == FLT_NONE)
      |-> rspPaddr[OFF_W-1:0] == vaReg[OFF_W-1:0]);
  // R3: bypass address is the presented virtual address
  a_r3_bypass_identity: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.loadBypass) |-> (rspPaddr == $past(reqVaddr) && rspAttr == 2'b00));
  // R11: faults leak no address or attributes
  a_r11_fault_clean: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault != FLT_NONE) |-> (rspPaddr == '0 && rspAttr == 2'b00));
endmodule

// File: rtl/sect_xlate.sv
module sect_xlate
  import sect_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] cfgTableBase,
  input  logic [31:0] cfgDomainAcc,
  input  logic        cfgEnable,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqVaddr,
  input  logic        reqWrite,
  input  logic        reqPriv,
  output logic        memRdValid,
  output logic [31:0] memRdAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  output logic        rspValid,
  output logic [31:0] rspPaddr,
  output logic [1:0]  rspAttr,
  output logic [1:0]  rspFault
);
  strobe_t strobe;
  fault_e  faultCode;

  sect_xlate_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .cfgEnable   (cfgEnable),
    .memRspValid (memRspValid),
    .reqReady    (reqReady),
    .memRdValid  (memRdValid),
    .rspValid    (rspValid),
    .strobe      (strobe)
  );

  sect_xlate_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqVaddr     (reqVaddr),
    .reqWrite     (reqWrite),
    .reqPriv      (reqPriv),
    .cfgTableBase (cfgTableBase),
    .cfgDomainAcc (cfgDomainAcc),
    .memRspData   (memRspData),
    .memRdAddr    (memRdAddr),
    .rspPaddr     (rspPaddr),
    .rspAttr      (rspAttr),
    .rspFault     (faultCode)
  );

  assign rspFault = faultCode;
endmodule

// File: tb/sect_xlate_bench.sv
`timescale 1ns/1ps
module sect_xlate_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] cfgTableBase = 32'h0010_C123;
  logic [31:0] cfgDomainAcc = 32'h0;
  logic cfgEnable = 1'b1;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [31:0] reqVaddr = 32'h0;
  logic reqWrite = 1'b0;
  logic reqPriv = 1'b0;
  logic memRdValid;
  logic [31:0] memRdAddr;
  logic memRspValid = 1'b0;
  logic [31:0] memRspData = 32'h0;
  logic rspValid;
  logic [31:0] rspPaddr;
  logic [1:0] rspAttr;
  logic [1:0] rspFault;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  sect_xlate u_sect_xlate (.*);

  localparam logic [1:0] FN = 2'b00, FX = 2'b01, FD = 2'b10, FP = 2'b11;

  function automatic logic [31:0] mkDesc(logic [11:0] sec, logic [1:0] ap,
                                         logic [3:0] dom, logic c, logic b,
                                         logic [1:0] typ);
    return {sec, 8'h00, ap, 1'b0, dom, 1'b1, c, b, typ};
  endfunction

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        pv;
    logic [31:0] dacr;
    logic [31:0] desc;
    logic [1:0]  expFault;
    logic [2:0]  lat;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1234_5678, 1'b1, 1'b0, 32'h0000_0003, mkDesc(12'hABC, 2'b00, 4'd0, 1'b1, 1'b0, 2'b10), FN, 3'd1, 4'd7},   // R7
    '{32'h0800_0010, 1'b1, 1'b0, 32'h0000_0040, mkDesc(12'h080, 2'b11, 4'd3, 1'b1, 1'b1, 2'b10), FN, 3'd3, 4'd10},  // R10
    '{32'h0800_0020, 1'b0, 1'b1, 32'h0000_0040, mkDesc(12'h080, 2'b00, 4'd3, 1'b0, 1'b0, 2'b10), FP, 3'd1, 4'd8},   // R8
    '{32'h3000_0004, 1'b0, 1'b1, 32'h0000_0400, mkDesc(12'h7F0, 2'b01, 4'd5, 1'b0, 1'b1, 2'b10), FN, 3'd2, 4'd9},   // R9
    '{32'h3000_0004, 1'b0, 1'b0, 32'h0000_0400, mkDesc(12'h7F0, 2'b01, 4'd5, 1'b0, 1'b1, 2'b10), FP, 3'd1, 4'd9},   // R9
    '{32'hC00F_FFF0, 1'b0, 1'b0, 32'h4000_0000, mkDesc(12'h001, 2'b10, 4'd15, 1'b1, 1'b1, 2'b10), FN, 3'd1, 4'd10}, // R10
    '{32'hC00F_FFF0, 1'b1, 1'b0, 32'h4000_0000, mkDesc(12'h001, 2'b10, 4'd15, 1'b1, 1'b1, 2'b10), FP, 3'd1, 4'd10}, // R10
    '{32'hC00F_FFF0, 1'b1, 1'b1, 32'h4000_0000, mkDesc(12'h001, 2'b10, 4'd15, 1'b1, 1'b1, 2'b10), FN, 3'd1, 4'd10}, // R10
    '{32'h0000_1000, 1'b0, 1'b1, 32'h0000_0003, mkDesc(12'h555, 2'b11, 4'd7, 1'b0, 1'b0, 2'b10), FD, 3'd1, 4'd6},   // R6
    '{32'h0000_1000, 1'b0, 1'b1, 32'h0000_0020, mkDesc(12'h555, 2'b11, 4'd2, 1'b0, 1'b0, 2'b10), FD, 3'd2, 4'd6},   // R6
    '{32'h0040_0000, 1'b0, 1'b1, 32'h0000_0003, mkDesc(12'h004, 2'b11, 4'd0, 1'b0, 1'b0, 2'b00), FX, 3'd1, 4'd5},   // R5
    '{32'h0040_0000, 1'b0, 1'b1, 32'h0000_0003, mkDesc(12'h004, 2'b11, 4'd7, 1'b0, 1'b0, 2'b01), FX, 3'd1, 4'd5},   // R5
    '{32'h0040_0000, 1'b0, 1'b1, 32'h0000_0003, mkDesc(12'h004, 2'b11, 4'd0, 1'b1, 1'b1, 2'b11), FX, 3'd1, 4'd5},   // R5
    '{32'hFFFF_FFFF, 1'b1, 1'b0, 32'h0000_0003, mkDesc(12'h000, 2'b00, 4'd0, 1'b0, 1'b1, 2'b10), FN, 3'd2, 4'd4},   // R4
    '{32'h7770_0008, 1'b1, 1'b0, 32'h0000_0100, mkDesc(12'h123, 2'b01, 4'd4, 1'b0, 1'b0, 2'b10), FP, 3'd1, 4'd9},   // R9
    '{32'h5555_AAAA, 1'b1, 1'b0, 32'h000C_0001, mkDesc(12'h9A9, 2'b01, 4'd9, 1'b1, 1'b0, 2'b10), FN, 3'd1, 4'd7}    // R7
  };

  task automatic chkEq(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic runVec(input int idx);
    vec_t v;
    string tag;
    logic [31:0] expAddr, expPa;
    logic [1:0] expAt;
    v = VECS[idx];
    tag = $sformatf("vec%0d R%0d", idx, v.req);
    expAddr = {cfgTableBase[31:14], v.va[31:20], 2'b00};
    expPa = (v.expFault == FN) ? {v.desc[31:20], v.va[19:0]} : 32'h0;  // R4 / R11
    expAt = (v.expFault == FN) ? v.desc[3:2] : 2'b00;
    @(negedge clk);
    cfgEnable = 1'b1;
    cfgDomainAcc = v.dacr;
    reqVaddr = v.va; reqWrite = v.wr; reqPriv = v.pv; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chkEq({tag, " R1 read strobe"}, {31'h0, memRdValid}, 32'h1);
    chkEq({tag, " R1 read address"}, memRdAddr, expAddr);
    chkEq({tag, " R2 ready low in fetch"}, {31'h0, reqReady}, 32'h0);
    for (int k = 0; k < int'(v.lat); k++) begin
      @(negedge clk);
      if (k == 0) chkEq({tag, " R1 single strobe"}, {31'h0, memRdValid}, 32'h0);
      chkEq({tag, " R2 no response while waiting"}, {31'h0, rspValid}, 32'h0);
    end
    memRspValid = 1'b1; memRspData = v.desc;
    @(negedge clk);
    memRspValid = 1'b0; memRspData = 32'h0;
    chkEq({tag, " R4 response valid"}, {31'h0, rspValid}, 32'h1);
    chkEq({tag, " fault code"}, {30'h0, rspFault}, {30'h0, v.expFault});
    chkEq({tag, " R4 physical address"}, rspPaddr, expPa);
    chkEq({tag, " R4 attributes"}, {30'h0, rspAttr}, {30'h0, expAt});
    chkEq({tag, " R2 ready low with response"}, {31'h0, reqReady}, 32'h0);
    @(negedge clk);
    chkEq({tag, " R2 ready back"}, {31'h0, reqReady}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 run hung actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset values
    chkEq("R13 ready in reset", {31'h0, reqReady}, 32'h1);
    chkEq("R13 strobe in reset", {31'h0, memRdValid}, 32'h0);
    chkEq("R13 response in reset", {31'h0, rspValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R13 ready after reset", {31'h0, reqReady}, 32'h1);
    chkEq("R13 response after reset", {31'h0, rspValid}, 32'h0);

    for (int i = 0; i < NVEC; i++) runVec(i);

    // R3: pass-through with enable clear
    foreach (VECS[i]) begin
      if (i < 2) begin
        @(negedge clk);
        cfgEnable = 1'b0;
        reqVaddr = (i == 0) ? 32'hDEAD_BEEF : 32'h0000_0001;
        reqWrite = 1'b1; reqPriv = 1'b0; reqValid = 1'b1;
        @(negedge clk);
        reqValid = 1'b0;
        chkEq("R3 bypass response valid", {31'h0, rspValid}, 32'h1);
        chkEq("R3 bypass address", rspPaddr, (i == 0) ? 32'hDEAD_BEEF : 32'h0000_0001);
        chkEq("R3 bypass fault", {30'h0, rspFault}, 32'h0);
        chkEq("R3 bypass attributes", {30'h0, rspAttr}, 32'h0);
        chkEq("R3 no read strobe", {31'h0, memRdValid}, 32'h0);
        @(negedge clk);
        chkEq("R3 no read strobe later", {31'h0, memRdValid}, 32'h0);
        chkEq("R2 ready after bypass", {31'h0, reqReady}, 32'h1);
      end
    end

    // R12: stray read data while idle
    @(negedge clk);
    cfgEnable = 1'b1;
    memRspValid = 1'b1; memRspData = mkDesc(12'h111, 2'b11, 4'd0, 1'b1, 1'b1, 2'b10);
    @(negedge clk);
    chkEq("R12 stray data no response", {31'h0, rspValid}, 32'h0);
    @(negedge clk);
    chkEq("R12 stray data no response 2", {31'h0, rspValid}, 32'h0);
    memRspValid = 1'b0;
    @(negedge clk);
    chkEq("R12 still idle", {31'h0, reqReady}, 32'h1);

    runVec(0);  // R7 again after the stray data

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule